// File: doc/BRIEF.md
# Cascadable Segment Line Loader

This block collects one display line of column data for a segment driver that can be chained with others on a shared data bus. On each clock where its chain enable input is active (low), it takes either a nibble or a byte from the parallel bus and stores it in a line buffer. The bus width is chosen by a width-select input. Each word goes to the next free column group, and bus bit 0 lands in the lowest-numbered column of that group.

The block counts the columns it has loaded. Once the buffer is full, it stops accepting data, which has the same effect as gating its internal shift clock. On the same edge it drives its own chain enable output low, so the next device on the bus starts loading. A rising edge on the latch strobe copies the buffer into the output line latch, clears the count, releases the enable output and re-arms the loader. While the active-low display-off input is held low, the output latch is cleared.

Top module: `seg_line_loader`

## Requirements
- R1: After reset, `line_q` is all zeros and `chain_en_out_n` is high.
- R2: With `bus_wide`=1, each accepted clock stores `bus_data[7:0]` into 8 consecutive columns starting at the current fill position, with bit k in column position+k. A full line of COLS columns takes COLS/8 accepted clocks (30 at the default width of 240).
- R3: With `bus_wide`=0, each accepted clock stores only `bus_data[3:0]`, with bit k in column position+k, and `bus_data[7:4]` has no effect. A full line takes COLS/4 accepted clocks (60 at the default).
- R4: A clock with `chain_en_in_n` high stores nothing and does not advance the fill position.
- R5: Once COLS columns are loaded, further bus data is ignored until the next latch strobe rising edge.
- R6: `chain_en_out_n` falls on the clock edge that stores the last column and stays low until the next latch strobe rising edge.
- R7: On a rising edge of `lp_strobe`, the buffer is copied to `line_q`, the fill position returns to column 0, and `chain_en_out_n` returns high. Holding `lp_strobe` high on later clocks triggers nothing more.
- R8: On every clock where `disp_off_n` is low, `line_q` is cleared. This takes priority over a latch transfer in the same cycle, and the line buffer keeps its contents.
- R9: Between latch strobe rising edges, `line_q` keeps its value while loading goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide | input | 1 | 1 selects byte-wide input, 0 selects nibble-wide input |
| bus_data | input | 8 | Parallel column data, bit 0 goes to the lowest column |
| chain_en_in_n | input | 1 | Active-low enable from the previous device in the chain |
| chain_en_out_n | output | 1 | Active-low enable passed to the next device |
| lp_strobe | input | 1 | Latch strobe, acts on its rising edge |
| disp_off_n | input | 1 | Active-low display off, clears the output latch |
| line_q | output | COLS (240) | Output line latch |

## Verification
The bench builds the block with COLS=48, so a line fills in 6 byte-wide clocks or 12 nibble-wide clocks. That makes it cheap to load many complete lines in both widths. Each line uses a different data pattern, and the chain enable is toggled in a different idle pattern. With lines this short, every column position is written, every fill position is reached, and the full-line boundary with its enable hand-off is crossed dozens of times. The bench also covers a strobe held high across loading and a display-off that coincides with a strobe edge.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

  // column groups (4 columns each) consumed per accepted clock
  function automatic int groups_per_clk(input logic wide);
    return wide ? 2 : 1;
  endfunction

  // fill position after one accepted clock, clamped at the end of the line
  function automatic int next_group(input int cur, input logic wide, input int ngrp);
    int sum;
    sum = cur + groups_per_clk(wide);
    if (sum > ngrp) sum = ngrp;
    return sum;
  endfunction

endpackage

// File: rtl/sl_group_counter.sv
module sl_group_counter #(
  parameter int NGRP = 60,
  localparam int GW  = $clog2(NGRP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wide,
  input  logic          chain_en_in_n,
  input  logic          lp_rise,
  output logic [GW-1:0] gcnt,
  output logic          load_fire,
  output logic          chain_en_out_n
);
  logic          line_full;
  logic [GW-1:0] gcnt_nxt;
  logic          last_hit;

  assign line_full = (gcnt >= GW'(NGRP));
  // internal clock enable: the gated shift clock of the loader
  assign load_fire = ~chain_en_in_n & ~line_full & ~lp_rise;
  assign gcnt_nxt  = GW'(seg_loader_pkg::next_group(int'(gcnt), bus_wide, NGRP));
  assign last_hit  = (gcnt_nxt == GW'(NGRP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt           <= '0;
      chain_en_out_n <= 1'b1;
    end else if (lp_rise) begin
      gcnt           <= '0;
      chain_en_out_n <= 1'b1;
    end else if (load_fire) begin
      gcnt <= gcnt_nxt;
      if (last_hit) chain_en_out_n <= 1'b0;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt <= GW'(NGRP));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en_in_n && !lp_rise) |=> $stable(gcnt));
  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_en_out_n && !lp_rise) |=> !chain_en_out_n);
  // R6
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chain_en_out_n) |-> (gcnt == GW'(NGRP)));
  // R7
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_rise |=> (chain_en_out_n && gcnt == '0));
endmodule

// File: rtl/sl_line_buffer.sv
module sl_line_buffer #(
  parameter int COLS = 240,
  localparam int NGRP = COLS / 4,
  localparam int GW   = $clog2(NGRP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_fire,
  input  logic            bus_wide,
  input  logic [GW-1:0]   gcnt,
  input  logic [7:0]      bus_data,
  output logic [COLS-1:0] line_buf
);
  logic [GW-1:0] gcnt_p1;
  assign gcnt_p1 = gcnt + GW'(1);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [GW-1:0] GIDX = GW'(g);
    logic       sel_lo;
    logic       sel_hi;
    logic [3:0] grp_q;

    assign sel_lo = load_fire && (gcnt == GIDX);
    assign sel_hi = load_fire && bus_wide && (gcnt_p1 == GIDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      grp_q <= '0;
      else if (sel_lo) grp_q <= bus_data[3:0];
      else if (sel_hi) grp_q <= bus_data[7:4];
    end

    assign line_buf[g*4 +: 4] = grp_q;
  end

  // R5
  buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable(line_buf));
endmodule

// File: rtl/sl_line_latch.sv
module sl_line_latch #(
  parameter int COLS = 240
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_rise,
  input  logic            disp_off_n,
  input  logic [COLS-1:0] line_buf,
  output logic [COLS-1:0] line_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          line_q <= '0;
    else if (!disp_off_n) line_q <= '0;
    else if (lp_rise)    line_q <= line_buf;
  end

  // R8
  dispoff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |=> (line_q == '0));
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_n && !lp_rise) |=> $stable(line_q));
  // R7
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_n && lp_rise) |=> (line_q == $past(line_buf)));
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader #(
  parameter int COLS = 240,
  localparam int NGRP = COLS / 4,
  localparam int GW   = $clog2(NGRP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wide,
  input  logic [7:0]      bus_data,
  input  logic            chain_en_in_n,
  output logic            chain_en_out_n,
  input  logic            lp_strobe,
  input  logic            disp_off_n,
  output logic [COLS-1:0] line_q
);
  logic            lp_prev;
  logic            lp_rise;
  logic            load_fire;
  logic [GW-1:0]   gcnt;
  logic [COLS-1:0] line_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_prev <= 1'b0;
    else        lp_prev <= lp_strobe;
  end
  assign lp_rise = lp_strobe & ~lp_prev;

  sl_group_counter #(.NGRP(NGRP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide),
    .chain_en_in_n(chain_en_in_n), .lp_rise(lp_rise),
    .gcnt(gcnt), .load_fire(load_fire), .chain_en_out_n(chain_en_out_n)
  );

  sl_line_buffer #(.COLS(COLS)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .bus_wide(bus_wide),
    .gcnt(gcnt), .bus_data(bus_data), .line_buf(line_buf)
  );

  sl_line_latch #(.COLS(COLS)) u_lat (
    .clk(clk), .rst_n(rst_n), .lp_rise(lp_rise), .disp_off_n(disp_off_n),
    .line_buf(line_buf), .line_q(line_q)
  );

  // R7
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_strobe && $past(lp_strobe)) |-> !lp_rise);
endmodule

// File: tb/seg_line_loader_test.sv
module seg_line_loader_test;
  localparam int CLK_NS = 10;
  localparam int COLS   = 48;
  localparam int NG     = COLS / 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wide = 1'b1;
  logic [7:0]      bus_data = '0;
  logic            chain_en_in_n = 1'b1;
  logic            chain_en_out_n;
  logic            lp_strobe = 1'b0;
  logic            disp_off_n = 1'b1;
  logic [COLS-1:0] line_q;

  int n_chk = 0;
  int n_fail = 0;

  logic [COLS-1:0] exp_buf = '0;
  logic [COLS-1:0] exp_q   = '0;
  logic            exp_en  = 1'b1;
  int              exp_cnt = 0;
  logic            lp_prev_b = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  seg_line_loader #(.COLS(COLS)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .bus_data(bus_data),
    .chain_en_in_n(chain_en_in_n), .chain_en_out_n(chain_en_out_n),
    .lp_strobe(lp_strobe), .disp_off_n(disp_off_n), .line_q(line_q)
  );

  task automatic check_outs(input string tag);
    n_chk++;
    if (line_q !== exp_q) begin
      n_fail++;
      $display("FAIL %s line_q actual %h expected %h", tag, line_q, exp_q);
    end
    n_chk++;
    if (chain_en_out_n !== exp_en) begin
      n_fail++;
      $display("FAIL %s chain_en_out_n actual %b expected %b", tag, chain_en_out_n, exp_en);
    end
  endtask

  // one clock: drive at negedge, advance the expected state, check after the edge
  task automatic cyc(input logic en_n, input logic wide, input logic [7:0] d,
                     input logic lp, input logic doff_n, input string tag);
    logic rise;
    int w;
    @(negedge clk);
    chain_en_in_n = en_n; bus_wide = wide; bus_data = d;
    lp_strobe = lp; disp_off_n = doff_n;
    rise = lp & ~lp_prev_b;
    lp_prev_b = lp;
    if (!doff_n)   exp_q = '0;
    else if (rise) exp_q = exp_buf;
    if (rise) begin
      exp_cnt = 0;
      exp_en  = 1'b1;
    end else if (!en_n && exp_cnt < NG) begin
      w = wide ? 2 : 1;
      for (int i = 0; i < w; i++)
        if (exp_cnt + i < NG) exp_buf[(exp_cnt + i)*4 +: 4] = d[i*4 +: 4];
      exp_cnt = (exp_cnt + w > NG) ? NG : exp_cnt + w;
      if (exp_cnt == NG) exp_en = 1'b0;
    end
    @(posedge clk);
    #1;
    check_outs(tag);
  endtask

  function automatic logic [7:0] pat(input int seed, input int step);
    return 8'((seed * 29 + step * 53 + 7) ^ (step << 3) ^ (seed << 5));
  endfunction

  // load one full line; gap_mod > 0 inserts an idle clock before every gap_mod-th word
  task automatic load_line(input logic wide, input int seed, input int gap_mod, input string tag);
    int words;
    words = wide ? NG / 2 : NG;
    for (int s = 0; s < words; s++) begin
      if (gap_mod > 0 && (s % gap_mod) == 0)
        cyc(1'b1, wide, ~pat(seed, s), 1'b0, 1'b1, "R4");
      cyc(1'b0, wide, pat(seed, s), 1'b0, 1'b1, tag);
    end
    // bus keeps moving after the line is full: must be ignored
    for (int s = 0; s < 3; s++) cyc(1'b0, wide, 8'hA5 ^ 8'(s), 1'b0, 1'b1, "R5");
  endtask

  task automatic latch_line(input string tag);
    cyc(1'b1, bus_wide, 8'h00, 1'b1, 1'b1, tag);
    cyc(1'b1, bus_wide, 8'h00, 1'b0, 1'b1, tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    check_outs("R1");
    rst_n = 1'b1;
    cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R1");

    // R2 byte-wide line, then R7 transfer
    load_line(1'b1, 1, 0, "R2");
    latch_line("R7");

    // R3 nibble-wide line with idle clocks (R4); R9 old line stays visible meanwhile
    load_line(1'b0, 2, 2, "R3");
    check_outs("R9");
    latch_line("R7");

    // R7 strobe held high while the next line starts: no second transfer
    cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R7");
    for (int s = 0; s < 3; s++) cyc(1'b0, 1'b1, pat(3, s), 1'b1, 1'b1, "R7");
    for (int s = 3; s < NG/2; s++) cyc(1'b0, 1'b1, pat(3, s), 1'b0, 1'b1, "R9");
    cyc(1'b0, 1'b1, 8'hFF, 1'b0, 1'b1, "R5");

    // R8 display-off coincides with strobe edge, then buffer still intact
    cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R8");
    cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R8");
    cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R8");
    latch_line("R8");

    // sweep: many lines in both widths with differing idle patterns
    for (int ln = 0; ln < 16; ln++) begin
      load_line(ln[0], 10 + ln, ln % 4, ln[0] ? "R2" : "R3");
      latch_line("R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule